// File: doc/BRIEF.md
# JTAG Configuration Command Sequencer

This block is a host-side engine that drives the three output wires of a JTAG port (test clock, mode select and data in) to take a target TAP controller through one fixed configuration command. One pulse on `start_i` runs the whole sequence. It first forces the target into Test-Logic-Reset and then walks to Shift-IR. There it loads a configuration-input instruction and moves on to Shift-DR. Seven 16-bit configuration packets from an internal ROM follow. The engine then returns to Shift-IR, loads a shutdown instruction, and ends with an idle period in Run-Test/Idle.

The test clock is the system clock divided by an even parameter of at least 4. Mode-select and data-in change only on falling test-clock edges. The target's data-out line is sampled on rising edges and handed out as a bit with a one-cycle valid strobe, so that a later readback stage can use it. Both instruction opcodes are parameters. `busy_o` covers the whole run, and `done_o` marks its end.

Top module: `jtag_cfg_seq`

## Requirements
- R1: `tck_o` has a period of exactly CLK_DIV system clocks, with CLK_DIV/2 cycles low followed by CLK_DIV/2 cycles high.
- R2: `tms_o` and `tdi_o` change only on the system clock edge where `tck_o` falls, and they hold steady while the sequencer is idle.
- R3: A run opens with five test-clock cycles of TMS=1, then TMS 0,1,1,0,0 (Run-Test/Idle, Select-DR, Select-IR, Capture-IR, Shift-IR). TDI is 0 throughout.
- R4: The configuration-input opcode (IR_W=6 bits) is shifted LSB first. Bits 0 to 4 go out with TMS=0, and bit 5 goes out with TMS=1 to leave Shift-IR.
- R5: After TMS 1,1,0,0 (Update-IR, Select-DR, Capture-DR, Shift-DR), the packets 0xFFFF, 0xAA99, 0x5566, 0x30A1, 0x0007, 0x2000, 0x2000 are shifted in that order, each MSB first. TMS is 0 for every bit except bit 0 of the last packet, which goes out with TMS=1.
- R6: Next come TMS 1,1,1,0,0 (Update-DR, Select-DR, Select-IR, Capture-IR, Shift-IR), and then the shutdown opcode is shifted LSB first with TMS=1 on its MSB.
- R7: The sequence finishes with one TMS=1 cycle (Update-IR) followed by exactly IDLE_TCKS=24 cycles of TMS=0. The target is then left in Run-Test/Idle.
- R8: `busy_o` rises on the clock after `start_i` is accepted. It stays high until the rising test-clock edge that samples the last idle bit. It falls in the same cycle that `done_o` pulses high, and `done_o` lasts exactly one clock.
- R9: A `start_i` pulse while `busy_o` is high is ignored: it neither restarts nor extends the run.
- R10: While reset is active: `tck_o`=0, `tms_o`=1, `tdi_o`=0, `busy_o`=0, `done_o`=0, `tdo_valid_o`=0.
- R11: On the clock after every rising `tck_o` edge at which the target is in Shift-IR or Shift-DR, `tdo_valid_o` pulses and `tdo_bit_o` holds the `tdo_i` value sampled at that edge. This gives 124 pulses per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one sequence when idle |
| busy_o | output | 1 | High while a sequence runs |
| done_o | output | 1 | One-clock pulse at sequence end |
| tck_o | output | 1 | Test clock to the target |
| tms_o | output | 1 | Test mode select to the target |
| tdi_o | output | 1 | Test data to the target |
| tdo_i | input | 1 | Test data from the target |
| tdo_bit_o | output | 1 | Last sampled data-out bit |
| tdo_valid_o | output | 1 | Strobe for `tdo_bit_o` during shift bits |

## Verification
The assertions watch four things on every clock: the test-clock duty, the rule that TMS and TDI move only on falling edges or not at all while idle, the tie between the end of `busy_o` and the one-clock `done_o`, and the alignment of the capture strobe with rising edges. Whether each test-clock cycle carries the right TMS/TDI pair can only be shown by the bench scenarios. The same holds for the instruction and packet contents captured by a TAP state tracker, the 24-cycle idle tail, the count of data-out samples, and the handling of a start pulse issued mid-run or from a non-reset TAP state.

// File: rtl/jtag_cfg_pkg.sv
package jtag_cfg_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_TLR, PH_NAV_IR0, PH_IR_CFG, PH_NAV_DR, PH_DR,
    PH_NAV_IR1, PH_IR_SD, PH_UPD, PH_RTI, PH_DONE
  } phase_e;

  typedef struct packed {
    logic tms;
    logic tdi;
    logic shift;
    logic last;
  } step_t;

  localparam int unsigned TLR_TCKS = 5;
  // TMS patterns, bit 0 sent first
  localparam logic [4:0] NAV_TO_IR0 = 5'b00110; // TLR -> Shift-IR
  localparam logic [3:0] NAV_TO_DR  = 4'b0011;  // Exit1-IR -> Shift-DR
  localparam logic [4:0] NAV_TO_IR1 = 5'b00111; // Exit1-DR -> Shift-IR

endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q, cnt_d;

  assign cnt_d  = (cnt_q == CW'(CLK_DIV - 1)) ? '0 : cnt_q + 1'b1;
  assign rise_o = (cnt_q == CW'(HALF - 1));
  assign fall_o = (cnt_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tck_o <= (cnt_d >= CW'(HALF));
    end
  end
endmodule

// File: rtl/jtag_cfg_rom.sv
module jtag_cfg_rom #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned N_WORDS = 7,
  localparam int unsigned AW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [AW-1:0]     addr_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    case (addr_i)
      AW'(0):  word_o = WORD_W'(16'hFFFF);
      AW'(1):  word_o = WORD_W'(16'hAA99);
      AW'(2):  word_o = WORD_W'(16'h5566);
      AW'(3):  word_o = WORD_W'(16'h30A1);
      AW'(4):  word_o = WORD_W'(16'h0007);
      AW'(5):  word_o = WORD_W'(16'h2000);
      AW'(6):  word_o = WORD_W'(16'h2000);
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/jtag_step_gen.sv
module jtag_step_gen
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned    IR_W        = 6,
  parameter logic [IR_W-1:0] CFG_IN_OP  = 6'h05,
  parameter logic [IR_W-1:0] SHUTDOWN_OP = 6'h0D,
  parameter int unsigned    WORD_W      = 16,
  parameter int unsigned    N_WORDS     = 7,
  parameter int unsigned    IDLE_TCKS   = 24,
  parameter int unsigned    CNT_W       = 7
) (
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  output step_t            step_o
);
  localparam int unsigned DR_BITS = N_WORDS * WORD_W;
  localparam int unsigned AW      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int unsigned BW      = $clog2(WORD_W);
  localparam int unsigned IW      = $clog2(IR_W);

  logic [AW-1:0]     word_idx;
  logic [BW-1:0]     bit_idx;
  logic [IW-1:0]     ir_idx;
  logic [2:0]        nav_idx;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  lim;

  assign word_idx = AW'(cnt_i / CNT_W'(WORD_W));
  assign bit_idx  = BW'(WORD_W - 1) - BW'(cnt_i % CNT_W'(WORD_W)); // MSB first
  assign ir_idx   = IW'(cnt_i);                                     // LSB first
  assign nav_idx  = cnt_i[2:0];

  jtag_cfg_rom #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_rom (
    .addr_i (word_idx),
    .word_o (word)
  );

  always_comb begin
    step_o = '0;
    lim    = '0;
    case (phase_i)
      PH_TLR:     begin step_o.tms = 1'b1;                 lim = CNT_W'(TLR_TCKS - 1); end
      PH_NAV_IR0: begin step_o.tms = NAV_TO_IR0[nav_idx];  lim = CNT_W'(4); end
      PH_IR_CFG:  begin step_o.tdi = CFG_IN_OP[ir_idx];    step_o.shift = 1'b1; lim = CNT_W'(IR_W - 1); end
      PH_NAV_DR:  begin step_o.tms = NAV_TO_DR[nav_idx[1:0]]; lim = CNT_W'(3); end
      PH_DR:      begin step_o.tdi = word[bit_idx];        step_o.shift = 1'b1; lim = CNT_W'(DR_BITS - 1); end
      PH_NAV_IR1: begin step_o.tms = NAV_TO_IR1[nav_idx];  lim = CNT_W'(4); end
      PH_IR_SD:   begin step_o.tdi = SHUTDOWN_OP[ir_idx];  step_o.shift = 1'b1; lim = CNT_W'(IR_W - 1); end
      PH_UPD:     begin step_o.tms = 1'b1;                 lim = '0; end
      PH_RTI:     begin step_o.tms = 1'b0;                 lim = CNT_W'(IDLE_TCKS - 1); end
      default:    ;
    endcase
    step_o.last = (cnt_i == lim);
    // final shift bit leaves the shift state
    if (step_o.shift) step_o.tms = step_o.last;
  end
endmodule

// File: rtl/jtag_cfg_seq.sv
module jtag_cfg_seq
  import jtag_cfg_pkg::*;
#(
  parameter int unsigned     CLK_DIV     = 4,
  parameter int unsigned     IR_W        = 6,
  parameter logic [IR_W-1:0] CFG_IN_OP   = 6'h05,
  parameter logic [IR_W-1:0] SHUTDOWN_OP = 6'h0D,
  parameter int unsigned     WORD_W      = 16,
  parameter int unsigned     N_WORDS     = 7,
  parameter int unsigned     IDLE_TCKS   = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic tck_o,
  output logic tms_o,
  output logic tdi_o,
  input  logic tdo_i,
  output logic tdo_bit_o,
  output logic tdo_valid_o
);
  localparam int unsigned DR_BITS = N_WORDS * WORD_W;
  localparam int unsigned MAXC0   = (DR_BITS > IDLE_TCKS) ? DR_BITS : IDLE_TCKS;
  localparam int unsigned MAXC    = (MAXC0 > 8) ? MAXC0 : 8;
  localparam int unsigned CNT_W   = $clog2(MAXC);

  logic             rise, fall;
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  step_t            step;
  logic             busy_q, done_q, tms_q, tdi_q, sh_q, tdo_bit_q, tdo_vld_q;

  jtag_tck_gen #(.CLK_DIV(CLK_DIV)) u_tck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tck_o  (tck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  jtag_step_gen #(
    .IR_W(IR_W), .CFG_IN_OP(CFG_IN_OP), .SHUTDOWN_OP(SHUTDOWN_OP),
    .WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDLE_TCKS(IDLE_TCKS), .CNT_W(CNT_W)
  ) u_step (
    .phase_i (phase_q),
    .cnt_i   (cnt_q),
    .step_o  (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      tms_q     <= 1'b1;
      tdi_q     <= 1'b0;
      sh_q      <= 1'b0;
      tdo_bit_q <= 1'b0;
      tdo_vld_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      tdo_vld_q <= 1'b0;
      if (rise) begin
        tdo_bit_q <= tdo_i;
        tdo_vld_q <= sh_q;
      end
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          phase_q <= PH_TLR;
          cnt_q   <= '0;
        end
      end else if (phase_q == PH_DONE) begin
        // end once the target has sampled the last idle bit
        if (rise) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
      end else if (fall) begin
        tms_q <= step.tms;
        tdi_q <= step.tdi;
        sh_q  <= step.shift;
        if (step.last) begin
          cnt_q   <= '0;
          phase_q <= phase_e'(phase_q + 4'd1);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;
  assign tdo_bit_o   = tdo_bit_q;
  assign tdo_valid_o = tdo_vld_q;
endmodule

// File: rtl/jtag_cfg_seq_chk.sv
module jtag_cfg_seq_chk #(
  parameter int unsigned CLK_DIV = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic tck_o,
  input logic tms_o,
  input logic tdi_o,
  input logic tdo_valid_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned LW   = $clog2(CLK_DIV) + 2;

  logic          last_tck_q, seen_q;
  logic [LW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_tck_q <= 1'b0;
      seen_q     <= 1'b0;
      run_q      <= LW'(1);
    end else begin
      last_tck_q <= tck_o;
      if (tck_o != last_tck_q) begin
        run_q  <= LW'(1);
        seen_q <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  p_tck_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && (tck_o != last_tck_q)) |-> (run_q == LW'(HALF)));

  p_tms_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tms_o != $past(tms_o)) |-> ($past(tck_o) && !tck_o));

  p_tdi_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tdi_o != $past(tdi_o)) |-> ($past(tck_o) && !tck_o));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> ($stable(tms_o) && $stable(tdi_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_tdo_on_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdo_valid_o |-> (tck_o && !$past(tck_o)));
endmodule

bind jtag_cfg_seq jtag_cfg_seq_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tck_o       (tck_o),
  .tms_o       (tms_o),
  .tdi_o       (tdi_o),
  .tdo_valid_o (tdo_valid_o)
);

// File: tb/jtag_cfg_seq_bench.sv
module jtag_cfg_seq_bench;
  localparam int unsigned CLK_DIV = 4;
  localparam int unsigned IR_W    = 6;
  localparam logic [5:0]  CFG_OP  = 6'b000101;
  localparam logic [5:0]  SD_OP   = 6'b001101;
  localparam logic [15:0] PKT [7] = '{16'hFFFF, 16'hAA99, 16'h5566, 16'h30A1,
                                      16'h0007, 16'h2000, 16'h2000};

  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} tap_e;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic tdo_i = 1'b0;
  logic busy_o, done_o, tck_o, tms_o, tdi_o, tdo_bit_o, tdo_valid_o;

  always #5 clk = ~clk;

  jtag_cfg_seq #(.CLK_DIV(CLK_DIV), .IR_W(IR_W), .CFG_IN_OP(CFG_OP),
                 .SHUTDOWN_OP(SD_OP)) u_jtag_cfg_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o),
    .tdo_i(tdo_i), .tdo_bit_o(tdo_bit_o), .tdo_valid_o(tdo_valid_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic tap_e tap_next(tap_e s, logic tms);
    case (s)
      TLR:  return tms ? TLR  : RTI;
      RTI:  return tms ? SDR  : RTI;
      SDR:  return tms ? SIR  : CDR;
      CDR:  return tms ? E1DR : SHDR;
      SHDR: return tms ? E1DR : SHDR;
      E1DR: return tms ? UDR  : PDR;
      PDR:  return tms ? E2DR : PDR;
      E2DR: return tms ? UDR  : SHDR;
      UDR:  return tms ? SDR  : RTI;
      SIR:  return tms ? TLR  : CIR;
      CIR:  return tms ? E1IR : SHIR;
      SHIR: return tms ? E1IR : SHIR;
      E1IR: return tms ? UIR  : PIR;
      PIR:  return tms ? E2IR : PIR;
      E2IR: return tms ? UIR  : SHIR;
      default: return tms ? SDR : RTI;
    endcase
  endfunction

  function automatic string req_of(int idx);
    if (idx < 10)  return "R3";
    if (idx < 16)  return "R4";
    if (idx < 132) return "R5";
    if (idx < 143) return "R6";
    return "R7";
  endfunction

  // scoreboard queues
  logic [1:0]  q_step[$];
  logic [5:0]  q_ir[$];
  logic [15:0] q_word[$];
  logic        q_tdo[$];

  tap_e st = TLR;
  logic [5:0]  ir_sh = '0;
  logic [15:0] wd = '0;
  int dr_bits = 0, step_idx = 0, n_ir = 0, n_tdo = 0, n_done = 0, viol = 0;
  logic armed = 1'b0, busy_prev = 1'b0;

  task automatic push(input logic tms, input logic tdi);
    q_step.push_back({tms, tdi});
  endtask

  task automatic load_sequence();
    step_idx = 0; n_ir = 0; n_tdo = 0; n_done = 0;
    for (int i = 0; i < 5; i++) push(1'b1, 1'b0);
    push(0, 0); push(1, 0); push(1, 0); push(0, 0); push(0, 0);
    for (int i = 0; i < 6; i++) push(i == 5, CFG_OP[i]);
    q_ir.push_back(CFG_OP);
    push(1, 0); push(1, 0); push(0, 0); push(0, 0);
    for (int w = 0; w < 7; w++) begin
      for (int b = 15; b >= 0; b--) push((w == 6) && (b == 0), PKT[w][b]);
      q_word.push_back(PKT[w]);
    end
    push(1, 0); push(1, 0); push(1, 0); push(0, 0); push(0, 0);
    for (int i = 0; i < 6; i++) push(i == 5, SD_OP[i]);
    q_ir.push_back(SD_OP);
    push(1, 0);
    for (int i = 0; i < 24; i++) push(0, 0);
  endtask

  // target model: data-out changes on falling edges
  initial begin
    logic [7:0] lf = 8'hA5;
    forever begin
      @(negedge tck_o);
      armed = busy_prev;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tdo_i <= lf[0];
    end
  end

  // monitor: TAP tracker on rising edges
  initial begin
    forever begin
      logic [1:0] e;
      logic [15:0] w;
      logic [5:0] x;
      tap_e nst;
      @(posedge tck_o);
      if (armed && q_step.size() > 0) begin
        e = q_step.pop_front();
        chk({tms_o, tdi_o} == e, req_of(step_idx), "tms/tdi step",
            {tms_o, tdi_o}, e);
        step_idx++;
      end
      if (st == SHIR) begin
        ir_sh = {tdi_o, ir_sh[5:1]};
        q_tdo.push_back(tdo_i);
      end
      if (st == SHDR) begin
        wd = {wd[14:0], tdi_o};
        dr_bits++;
        q_tdo.push_back(tdo_i);
        if ((dr_bits % 16 == 0) && q_word.size() > 0) begin
          w = q_word.pop_front();
          chk(wd == w, "R5", "packet word captured", wd, w);
        end
      end
      nst = tap_next(st, tms_o);
      if (nst == SHDR && st != SHDR) dr_bits = 0;
      if (nst == UIR && q_ir.size() > 0) begin
        x = q_ir.pop_front();
        chk(ir_sh == x, (n_ir == 0) ? "R4" : "R6", "instruction captured", ir_sh, x);
        n_ir++;
      end
      st = nst;
    end
  end

  // per-clock observers away from the active edge
  initial begin
    logic tck_p = 1'b0, tms_p = 1'b1, tdi_p = 1'b0;
    int cyc = 0, last_rise = -1, n_per = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_ni) begin
        if ((tms_o != tms_p || tdi_o != tdi_p) && !(tck_p && !tck_o)) viol++;
        if (tck_o && !tck_p) begin
          if (last_rise >= 0 && n_per < 4) begin
            chk(cyc - last_rise == CLK_DIV, "R1", "tck period", cyc - last_rise, CLK_DIV);
            n_per++;
          end
          last_rise = cyc;
        end
        if (tdo_valid_o) begin
          n_tdo++;
          if (q_tdo.size() > 0) begin
            logic t;
            t = q_tdo.pop_front();
            chk(tdo_bit_o == t, "R11", "tdo capture", tdo_bit_o, t);
          end else chk(1'b0, "R11", "unexpected tdo strobe", 1, 0);
        end
        if (done_o) n_done++;
      end
      tck_p = tck_o; tms_p = tms_o; tdi_p = tdi_o; busy_prev = busy_o;
    end
  end

  task automatic run_once(input string tag);
    load_sequence();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", {tag, " busy after start"}, busy_o, 1);
    repeat (37) @(negedge clk);
    start_i = 1'b1;                         // R9: start while busy
    @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk(busy_o == 1'b0, "R8", {tag, " busy low with done"}, busy_o, 0);
    chk(q_step.size() == 0, "R7", {tag, " steps left"}, q_step.size(), 0);
    chk(q_word.size() == 0, "R5", {tag, " packets left"}, q_word.size(), 0);
    chk(q_ir.size() == 0, "R6", {tag, " instructions left"}, q_ir.size(), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R8", {tag, " done one clock"}, done_o, 0);
    repeat (40) @(negedge clk);
    chk(busy_o == 1'b0, "R9", {tag, " no restart"}, busy_o, 0);
    chk(n_done == 1, "R9", {tag, " done count"}, n_done, 1);
    chk(st == RTI, "R7", {tag, " target parked"}, st, RTI);
    chk(n_tdo == 124, "R11", {tag, " tdo strobes"}, n_tdo, 124);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({tck_o, tms_o, tdi_o, busy_o, done_o, tdo_valid_o} == 6'b010000,
        "R10", "reset outputs", {tck_o, tms_o, tdi_o, busy_o, done_o, tdo_valid_o}, 6'b010000);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk(st == TLR, "R2", "idle holds reset state", st, TLR);
    run_once("run1");
    run_once("run2");                       // starts from Run-Test/Idle
    chk(viol == 0, "R2", "tms/tdi moved off falling edge", viol, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual busy=%0d expected done", busy_o);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule